// File: doc/BRIEF.md
# Soft-Start Current Limit Sequencer

This block steps the switch current limit of a step-down regulator up through four levels when the regulator is brought out of shutdown, so the output capacitor does not draw a large in-rush current. The sequence is armed only by a release of the global shutdown control from 1 to 0. That release must come after the supply-good flag has reported that the input supply is at or above its minimum start level (2.7 V).

Both the shutdown control and the supply-good flag arrive asynchronously. They pass through a two-stage synchroniser inside the block and are then edge-detected there. A level lasts a programmable number of clock cycles. When the regulation-reached flag asserts, the sequencer moves to the next level at once. After the highest level has run its time, the sequencer reports that soft start is complete and keeps the highest limit. Setting shutdown again at any time returns the sequencer to idle.

Top module: `ss_ilim_seq`

## Requirements
- R1: After a synchronous active-low reset, `ilim_code` is 0 and `ss_active` is 0.
- R2: A 1-to-0 change of `shdn_async` while `supply_ok_async` is 1 starts the ramp. At the third rising edge after the change, `ss_active` becomes 1 and `ilim_code` is 0.
- R3: A release while the supply is not good does not start the ramp. If the supply becomes good later while shutdown stays at 0, the ramp still does not start. A new release is needed.
- R4: During the ramp, each level holds for `step_cycles` cycles before `ilim_code` rises by one. A `step_cycles` value of 0 behaves as 1.
- R5: While ramping, `reg_reached` high at a rising edge advances the level at that edge. Outside the ramp, `reg_reached` has no effect on either output.
- R6: The level codes stand for 0 = 70 mA, 1 = 140 mA, 2 = 280 mA and 3 = 750 mA. While `ss_active` stays high, the code never falls and rises by at most one per cycle.
- R7: When level 3 ends, `ss_active` drops to 0 and `ilim_code` stays at 3 until shutdown is set again.
- R8: When `shdn_async` goes to 1, from any state, the sequencer returns to idle with `ilim_code` 0 and `ss_active` 0 at the third rising edge after the change.
- R9: The outputs do not respond to a shutdown change before the third rising edge; the two-stage synchroniser sets this latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_async | input | 1 | Global shutdown control, asynchronous; 1 = shut down |
| supply_ok_async | input | 1 | Supply at or above the start level, asynchronous |
| reg_reached | input | 1 | Regulator output reached its target; synchronous to clk |
| step_cycles | input | CNT_W | Cycles per limit level; 0 is treated as 1 |
| ilim_code | output | 2 | Current-limit level code, 0 to 3 |
| ss_active | output | 1 | High while the ramp is in progress |

## Verification
The bench targets four cases:
- A release while the supply is bad, followed later by the supply coming good. A design that treats supply-good as the trigger would start the ramp here.
- A shutdown that arrives partway through a level. A design that misses it would keep ramping, and a design that reacts too early would break the synchroniser latency.
- A `reg_reached` pulse that is held across the start and across every level. A design that lets it act in idle, or skips a level, would show the wrong code.
- A `step_cycles` value of 0. A design that wraps its counter would hold a level for a full counter range instead of one cycle.

// File: rtl/ss_pkg.sv
// Shared types for the soft-start current limit sequencer.
// Assumes a four-level limit, encoded on two bits.
package ss_pkg;
    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_DONE = 2'd2
    } ss_state_t;

    typedef logic [1:0] ilim_code_t;

    localparam ilim_code_t ILIM_LOWEST  = 2'd0;
    localparam ilim_code_t ILIM_HIGHEST = 2'd3;
endpackage

// File: rtl/ss_sync.sv
// Multi-bit synchroniser chain with falling-edge detection.
// Assumes every bit is a slow level signal, so each bit is synchronised on
// its own with no coherence between bits. Reset loads RESET_VAL into every
// stage, so no edge is reported when reset is released.
module ss_sync #(
    parameter int WIDTH     = 2,
    parameter int STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RESET_VAL;
                    else        stg[g] <= async_i;
                end
            end else begin : g_next
                // Later stages: move the value one step down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RESET_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];

    // Remember last cycle's synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= sync_o;
    end

    assign fall_o = prev_q & ~sync_o;
endmodule

// File: rtl/ss_step_timer.sv
// Step duration counter. It counts cycles while run_i is high and clears
// when run_i is low or clear_i is high. expire_o flags the last cycle of
// a step. A limit of 0 is treated like a limit of 1.
module ss_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_plus1;

    assign cnt_plus1 = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign expire_o  = run_i && (cnt_plus1 >= {1'b0, limit_i});

    // Count cycles within the current step; restart at every step change.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run_i || clear_i) cnt_q <= '0;
        else                       cnt_q <= cnt_plus1[CNT_W-1:0];
    end
endmodule

// File: rtl/ss_seq_fsm.sv
// Sequencer state machine: idle, ramping through limit levels, and done.
// Assumes its inputs are already synchronised. Shutdown overrides every
// other input.
module ss_seq_fsm
    import ss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_i,
    input  logic       shdn_fall_i,
    input  logic       supply_ok_i,
    input  logic       step_expire_i,
    input  logic       reg_reached_i,
    output logic       step_adv_o,
    output logic       ramping_o,
    output ilim_code_t level_o
);
    ss_state_t  state_q;
    ilim_code_t level_q;
    logic       start;

    assign start      = shdn_fall_i && supply_ok_i;
    assign ramping_o  = (state_q == SS_RAMP);
    assign step_adv_o = ramping_o && (step_expire_i || reg_reached_i);
    assign level_o    = level_q;

    // Advance the state and the limit level.
    always_ff @(posedge clk) begin
        if (!rst_n || shdn_i) begin
            state_q <= SS_IDLE;
            level_q <= ILIM_LOWEST;
        end else begin
            unique case (state_q)
                SS_IDLE: begin
                    if (start) begin
                        state_q <= SS_RAMP;
                        level_q <= ILIM_LOWEST;
                    end
                end
                SS_RAMP: begin
                    if (step_adv_o) begin
                        if (level_q == ILIM_HIGHEST) state_q <= SS_DONE;
                        else                         level_q <= level_q + 2'd1;
                    end
                end
                SS_DONE: begin
                    level_q <= ILIM_HIGHEST;
                end
                default: begin
                    state_q <= SS_IDLE;
                    level_q <= ILIM_LOWEST;
                end
            endcase
        end
    end
endmodule

// File: rtl/ss_ilim_seq.sv
// Top of the soft-start current limit sequencer. It synchronises the
// shutdown and supply-good inputs, times each limit level, and sequences
// the level codes 0..3. reg_reached must already be synchronous to clk.
module ss_ilim_seq
    import ss_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn_async,
    input  logic             supply_ok_async,
    input  logic             reg_reached,
    input  logic [CNT_W-1:0] step_cycles,
    output logic [1:0]       ilim_code,
    output logic             ss_active
);
    localparam int SYNC_W = 2;
    localparam int IDX_SHDN = 0;
    localparam int IDX_SUP  = 1;
    localparam logic [SYNC_W-1:0] SYNC_RST = 2'b01;

    logic [SYNC_W-1:0] sync_in, sync_lvl, sync_fall;
    logic              shdn_s;
    logic              step_expire;
    logic              step_adv;
    logic              ramping;
    ilim_code_t        level;

    assign sync_in[IDX_SHDN] = shdn_async;
    assign sync_in[IDX_SUP]  = supply_ok_async;
    assign shdn_s            = sync_lvl[IDX_SHDN];

    ss_sync #(
        .WIDTH    (SYNC_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(sync_in),
        .sync_o (sync_lvl),
        .fall_o (sync_fall)
    );

    ss_step_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ramping),
        .clear_i (step_adv),
        .limit_i (step_cycles),
        .expire_o(step_expire)
    );

    ss_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .shdn_i       (shdn_s),
        .shdn_fall_i  (sync_fall[IDX_SHDN]),
        .supply_ok_i  (sync_lvl[IDX_SUP]),
        .step_expire_i(step_expire),
        .reg_reached_i(reg_reached),
        .step_adv_o   (step_adv),
        .ramping_o    (ramping),
        .level_o      (level)
    );

    assign ilim_code = level;
    assign ss_active = ramping;
endmodule

// File: rtl/ss_ilim_seq_chk.sv
// Property checker for ss_ilim_seq, attached by the bind below.
module ss_ilim_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_sync,
    input logic       timer_expire,
    input logic       reg_reached,
    input logic [1:0] ilim_code,
    input logic       ss_active
);
    logic past_ok;

    // Mark cycles that have a valid previous sample since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: the ramp always starts at the lowest level
    a_r2_start_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(ss_active)) |-> (ilim_code == 2'd0));

    // R6: the code rises by at most one and never falls while ramping
    a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ss_active && $past(ss_active)) |->
        ((ilim_code == $past(ilim_code)) || (ilim_code == $past(ilim_code) + 2'd1)));

    // R4: a level changes only after the timer expires or regulation is reached
    a_r4_no_early_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ss_active && $past(ss_active) && (ilim_code != $past(ilim_code))) |->
        ($past(timer_expire) || $past(reg_reached)));

    // R8: a synchronised shutdown forces idle on the next cycle
    a_r8_shdn_idle: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_sync |=> (!ss_active && (ilim_code == 2'd0)));

    // R7: outside the ramp the code is either lowest or held at highest
    a_r7_idle_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_active |-> ((ilim_code == 2'd0) || (ilim_code == 2'd3)));
endmodule

bind ss_ilim_seq ss_ilim_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shdn_sync   (shdn_s),
    .timer_expire(step_expire),
    .reg_reached (reg_reached),
    .ilim_code   (ilim_code),
    .ss_active   (ss_active)
);

// File: tb/test_ss_ilim_seq.sv
`timescale 1ns/1ps
module test_ss_ilim_seq;
    localparam int CNT_W = 16;
    localparam int NV    = 25;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             shdn_async = 1'b1;
    logic             supply_ok_async = 1'b0;
    logic             reg_reached = 1'b0;
    logic [CNT_W-1:0] step_cycles = 16'd8;
    logic [1:0]       ilim_code;
    logic             ss_active;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    ss_ilim_seq #(.CNT_W(CNT_W)) i_ss_ilim_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .shdn_async     (shdn_async),
        .supply_ok_async(supply_ok_async),
        .reg_reached    (reg_reached),
        .step_cycles    (step_cycles),
        .ilim_code      (ilim_code),
        .ss_active      (ss_active)
    );

    // Row: {shdn, supply_ok, reg_reached, wait[7:0], exp_code[1:0], exp_active, tag[3:0]}
    localparam logic [17:0] VEC [0:NV-1] = '{
        {1'b1,1'b1,1'b0,8'd4 ,2'd0,1'b0,4'd1}, // R1 idle with supply good
        {1'b0,1'b1,1'b0,8'd3 ,2'd0,1'b1,4'd2}, // R2 release starts ramp
        {1'b0,1'b1,1'b0,8'd8 ,2'd1,1'b1,4'd4}, // R4 level 1 after 8 cycles
        {1'b0,1'b1,1'b0,8'd8 ,2'd2,1'b1,4'd4}, // R4 level 2
        {1'b0,1'b1,1'b1,8'd1 ,2'd3,1'b1,4'd5}, // R5 early advance
        {1'b0,1'b1,1'b0,8'd7 ,2'd3,1'b1,4'd6}, // R6 level 3 still running
        {1'b0,1'b1,1'b0,8'd1 ,2'd3,1'b0,4'd7}, // R7 done
        {1'b0,1'b1,1'b0,8'd20,2'd3,1'b0,4'd7}, // R7 held
        {1'b1,1'b1,1'b0,8'd2 ,2'd3,1'b0,4'd9}, // R9 not yet seen
        {1'b1,1'b1,1'b0,8'd1 ,2'd0,1'b0,4'd8}, // R8 idle
        {1'b1,1'b0,1'b1,8'd5 ,2'd0,1'b0,4'd5}, // R5 ignored while idle
        {1'b0,1'b0,1'b0,8'd12,2'd0,1'b0,4'd3}, // R3 release with bad supply
        {1'b0,1'b1,1'b0,8'd12,2'd0,1'b0,4'd3}, // R3 supply good later, no start
        {1'b1,1'b1,1'b0,8'd4 ,2'd0,1'b0,4'd8}, // R8 back to shutdown
        {1'b0,1'b1,1'b1,8'd3 ,2'd0,1'b1,4'd5}, // R5 held flag, start at 0
        {1'b0,1'b1,1'b1,8'd1 ,2'd1,1'b1,4'd5}, // R5
        {1'b0,1'b1,1'b1,8'd1 ,2'd2,1'b1,4'd5}, // R5
        {1'b0,1'b1,1'b1,8'd1 ,2'd3,1'b1,4'd5}, // R5
        {1'b0,1'b1,1'b1,8'd1 ,2'd3,1'b0,4'd7}, // R7 done after fast ramp
        {1'b1,1'b1,1'b0,8'd3 ,2'd0,1'b0,4'd8}, // R8
        {1'b0,1'b1,1'b0,8'd3 ,2'd0,1'b1,4'd2}, // R2
        {1'b0,1'b1,1'b0,8'd12,2'd1,1'b1,4'd4}, // R4 mid level 1
        {1'b1,1'b1,1'b0,8'd2 ,2'd1,1'b1,4'd9}, // R9 abort not yet seen
        {1'b1,1'b1,1'b0,8'd1 ,2'd0,1'b0,4'd8}, // R8 abort mid-ramp
        {1'b0,1'b1,1'b0,8'd3 ,2'd0,1'b1,4'd2}  // R2 restart
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input logic [1:0] ecode, input logic eact, input string tag);
        n_chk++;
        if (ilim_code !== ecode || ss_active !== eact) begin
            n_bad++;
            $display("FAIL %s: code=%0d exp=%0d active=%0d exp=%0d",
                     tag, ilim_code, ecode, ss_active, eact);
        end
    endtask

    task automatic run_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d exp<=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        run_edges(3);
        check(2'd0, 1'b0, "R1");            // R1 reset state
        rst_n = 1'b1;
        run_edges(2);
        check(2'd0, 1'b0, "R1");

        for (int i = 0; i < NV; i++) begin
            shdn_async      = VEC[i][17];
            supply_ok_async = VEC[i][16];
            reg_reached     = VEC[i][15];
            run_edges(int'(VEC[i][14:7]));
            check(VEC[i][6:5], VEC[i][4], tag_name(VEC[i][3:0]));
        end

        // R1: reset in the middle of a ramp
        run_edges(4);
        check(2'd0, 1'b1, "R2");
        shdn_async = 1'b1;
        rst_n = 1'b0;
        run_edges(1);
        check(2'd0, 1'b0, "R1");
        rst_n = 1'b1;
        run_edges(4);
        check(2'd0, 1'b0, "R1");

        // R4: step_cycles of 0 behaves as one cycle per level
        step_cycles = '0;
        shdn_async = 1'b0;
        run_edges(3);
        check(2'd0, 1'b1, "R4");
        run_edges(1);
        check(2'd1, 1'b1, "R4");
        run_edges(1);
        check(2'd2, 1'b1, "R4");
        run_edges(1);
        check(2'd3, 1'b1, "R4");
        run_edges(1);
        check(2'd3, 1'b0, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule